// File: doc/BRIEF.md
# CAN Reset-Mode and Bus-On Recovery Controller

This block owns the reset-request control bit of a stand-alone CAN controller and decides when the controller may rejoin bus traffic. A microcontroller writes the bit through a small register write port. An external active-low reset pin and a bus-off indication from the error logic can also force the bit to 1. A software write does not act at once. It is held until the next enable of an internal clock that runs at half the oscillator rate, and the read port shows only the value after that update.

When the request bit rises, the block emits a one-cycle abort strobe so the frame engine can drop the frame in progress. It also clears the bus-on indication at the same internal edge. When the bit falls, the block watches the sampled receive bits at each bit-time strobe and counts bus-free intervals. A bus-free interval is 11 recessive bits in a row. The block must see 1 interval if the last reset came from hardware or software, and 128 intervals if it came from bus-off. A flag stored when the request is set records which case applies.

Top module: `can_reset_recovery`

## Requirements
- R1: After the system reset, `rst_mode` is 1, `bus_on` is 0 and reading the control address returns 8'h01.
- R2: Reading the command address (address 1) returns 8'hFF. A write to the command address does not change `rst_mode`.
- R3: A write to the control address (address 0) loads `wr_rr` into the reset-request bit within two oscillator clocks, at an internal clock-enable edge. Bit 0 of the control read data returns that updated value.
- R4: After a reset caused by hardware or software is released, `bus_on` stays 0 through 10 recessive strobed bits and goes to 1 on the 11th (`rx_bit` = 1 is recessive).
- R5: A dominant strobed bit (`rx_bit` = 0) before the 11th recessive bit restarts the recessive count for the current bus-free interval.
- R6: `bus_off` high at an internal enable forces the reset request to 1. After the request is released, 128 bus-free intervals are required: `bus_on` is still 0 after 1407 recessive bits and is 1 after 1408.
- R7: While `reset_pin_n` is low, the reset request is held at 1 and writes of 0 are ignored. After the pin goes high the bit stays 1 until software writes 0, and the recovery then needs one bus-free interval.
- R8: Setting the reset request to 1 again during the bus-free wait clears the recessive count and the interval count.
- R9: `frame_abort` is high for exactly one oscillator clock each time the reset request goes from 0 to 1, and never when it is already 1.
- R10: `bus_on` is never 1 while `rst_mode` is 1, and it falls at the same edge where `rst_mode` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | System reset, active low, asynchronous assert and synchronous release |
| reset_pin_n | input | 1 | External reset pin, active low, asynchronous to `clk` |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_rr | input | 1 | Reset-request bit of the write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data |
| bus_off | input | 1 | Bus-off status from the error logic |
| bit_strobe | input | 1 | One-clock strobe per sampled bit time |
| rx_bit | input | 1 | Sampled receive bit (1 = recessive) |
| rst_mode | output | 1 | Synchronized reset-request flag |
| frame_abort | output | 1 | Abort strobe for the frame in progress |
| bus_on | output | 1 | Controller is in operating mode on the bus |

## Verification
Recovery is driven with unbroken recessive runs that stop one bit short of the threshold and then reach it. This tells an early bus-on apart from a correct one for both reset causes. A sweep places one dominant bit at each of the 11 positions of a run. Only a count that restarts from zero keeps `bus_on` low until 11 more recessive bits have passed. Re-asserting the request partway through a run, and holding the pin low during a release write, show apart a wait that really restarts and a write that is really ignored.

// File: rtl/can_rm_pkg.sv
package can_rm_pkg;
  localparam int unsigned REG_W = 8;

  typedef enum logic {
    CAUSE_LOCAL  = 1'b0,
    CAUSE_BUSOFF = 1'b1
  } rst_cause_e;
endpackage

// File: rtl/cr_sync.sv
module cr_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q[0] <= RST_VAL;
    else         chain_q[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q[i] <= RST_VAL;
        else         chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cr_clkdiv.sv
module cr_clkdiv (
  input  logic clk,
  input  logic rst_n,
  output logic ce
);
  logic ph_q, ph_d;

  always_comb ph_d = ~ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end

  assign ce = ph_q;
endmodule

// File: rtl/cr_req_ctrl.sv
module cr_req_ctrl
  import can_rm_pkg::*;
#(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned CTRL_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_rr,
  input  logic              pin_ok,
  input  logic              bus_off,
  output logic              rr_q,
  output rst_cause_e        cause_q,
  output logic              go_reset,
  output logic              abort_q
);
  logic       rr_d, pend_q, pend_d, pval_q, pval_d, abort_d;
  rst_cause_e cause_d;
  logic       wr_hit;

  assign wr_hit = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

  always_comb begin
    rr_d    = rr_q;
    cause_d = cause_q;
    pend_d  = pend_q;
    pval_d  = pval_q;
    if (ce) begin
      if (bus_off) begin
        rr_d    = 1'b1;
        cause_d = CAUSE_BUSOFF;
        pend_d  = 1'b0;
      end else if (!pin_ok) begin
        rr_d    = 1'b1;
        cause_d = CAUSE_LOCAL;
        pend_d  = 1'b0;
      end else if (pend_q) begin
        rr_d   = pval_q;
        pend_d = 1'b0;
        if (pval_q) cause_d = CAUSE_LOCAL;
      end
    end
    if (wr_hit) begin
      pend_d = 1'b1;
      pval_d = wr_rr;
    end
    abort_d  = ce && rr_d && !rr_q;
    go_reset = ce && rr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q    <= 1'b1;
      cause_q <= CAUSE_LOCAL;
      pend_q  <= 1'b0;
      pval_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      rr_q    <= rr_d;
      cause_q <= cause_d;
      pend_q  <= pend_d;
      pval_q  <= pval_d;
      abort_q <= abort_d;
    end
  end
endmodule

// File: rtl/cr_busfree.sv
module cr_busfree
  import can_rm_pkg::*;
#(
  parameter int unsigned RUN_LEN    = 11,
  parameter int unsigned LOCAL_OCC  = 1,
  parameter int unsigned BUSOFF_OCC = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_reset,
  input  logic       rr_q,
  input  rst_cause_e cause,
  input  logic       bit_strobe,
  input  logic       rx_bit,
  output logic       bus_on_q
);
  localparam int unsigned RUN_W   = $clog2(RUN_LEN);
  localparam int unsigned MAX_OCC = (LOCAL_OCC > BUSOFF_OCC) ? LOCAL_OCC : BUSOFF_OCC;
  localparam int unsigned OCC_W   = $clog2(MAX_OCC + 1);

  logic [RUN_W-1:0] run_q, run_d;
  logic [OCC_W-1:0] occ_q, occ_d, occ_last;
  logic             bus_on_d, waiting;

  assign occ_last = (cause == CAUSE_BUSOFF) ? OCC_W'(BUSOFF_OCC - 1) : OCC_W'(LOCAL_OCC - 1);
  assign waiting  = !rr_q && !bus_on_q;

  always_comb begin
    run_d    = run_q;
    occ_d    = occ_q;
    bus_on_d = bus_on_q;
    if (go_reset || rr_q) begin
      run_d    = '0;
      occ_d    = '0;
      bus_on_d = 1'b0;
    end else if (waiting && bit_strobe) begin
      if (!rx_bit) begin
        run_d = '0;
      end else if (run_q == RUN_W'(RUN_LEN - 1)) begin
        run_d = '0;
        if (occ_q == occ_last) begin
          occ_d    = '0;
          bus_on_d = 1'b1;
        end else begin
          occ_d = occ_q + 1'b1;
        end
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= '0;
      occ_q    <= '0;
      bus_on_q <= 1'b0;
    end else begin
      run_q    <= run_d;
      occ_q    <= occ_d;
      bus_on_q <= bus_on_d;
    end
  end
endmodule

// File: rtl/can_reset_recovery.sv
module can_reset_recovery
  import can_rm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned CTRL_ADDR   = 0,
  parameter int unsigned CMD_ADDR    = 1,
  parameter int unsigned RUN_LEN     = 11,
  parameter int unsigned LOCAL_OCC   = 1,
  parameter int unsigned BUSOFF_OCC  = 128,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_pin_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_rr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              bus_off,
  input  logic              bit_strobe,
  input  logic              rx_bit,
  output logic              rst_mode,
  output logic              frame_abort,
  output logic              bus_on
);
  logic       rst_sync_n, pin_ok, int_ce, go_reset;
  rst_cause_e cause;

  cr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .arst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );

  cr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
    .clk(clk), .arst_n(rst_sync_n), .d(reset_pin_n), .q(pin_ok)
  );

  cr_clkdiv u_div (.clk(clk), .rst_n(rst_sync_n), .ce(int_ce));

  cr_req_ctrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_req (
    .clk(clk), .rst_n(rst_sync_n), .ce(int_ce),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_rr(wr_rr),
    .pin_ok(pin_ok), .bus_off(bus_off),
    .rr_q(rst_mode), .cause_q(cause), .go_reset(go_reset), .abort_q(frame_abort)
  );

  cr_busfree #(.RUN_LEN(RUN_LEN), .LOCAL_OCC(LOCAL_OCC), .BUSOFF_OCC(BUSOFF_OCC)) u_bf (
    .clk(clk), .rst_n(rst_sync_n), .go_reset(go_reset), .rr_q(rst_mode),
    .cause(cause), .bit_strobe(bit_strobe), .rx_bit(rx_bit), .bus_on_q(bus_on)
  );

  always_comb begin
    if (rd_addr == ADDR_W'(CMD_ADDR))       rd_data = '1;
    else if (rd_addr == ADDR_W'(CTRL_ADDR)) rd_data = {{(REG_W-1){1'b0}}, rst_mode};
    else                                    rd_data = '0;
  end
endmodule

// File: rtl/can_reset_recovery_chk.sv
module can_reset_recovery_chk (
  input logic clk,
  input logic rst_n,
  input logic ce,
  input logic pin_ok,
  input logic bus_off,
  input logic bit_strobe,
  input logic rx_bit,
  input logic rst_mode,
  input logic frame_abort,
  input logic bus_on
);
  AST_BUSON_OFF_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_mode |-> !bus_on); // R10

  AST_ABORT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |-> (rst_mode && !$past(rst_mode))); // R9

  AST_BUSOFF_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off && ce) |=> rst_mode); // R6

  AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_ok && ce) |=> rst_mode); // R7

  AST_UPDATE_ON_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(rst_mode)); // R3

  AST_BUSON_AFTER_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_on) |-> $past(bit_strobe && rx_bit)); // R4
endmodule

bind can_reset_recovery can_reset_recovery_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .ce(int_ce), .pin_ok(pin_ok),
  .bus_off(bus_off), .bit_strobe(bit_strobe), .rx_bit(rx_bit),
  .rst_mode(rst_mode), .frame_abort(frame_abort), .bus_on(bus_on)
);

// File: tb/can_reset_recovery_test.sv
module can_reset_recovery_test;
  logic       clk = 1'b0;
  logic       rst_n, reset_pin_n, wr_en, wr_rr, bus_off, bit_strobe, rx_bit;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] rd_data;
  logic       rst_mode, frame_abort, bus_on;
  int         checks = 0;
  int         errors = 0;
  int         aborts = 0;

  always #4 clk = ~clk;

  can_reset_recovery uut (
    .clk(clk), .rst_n(rst_n), .reset_pin_n(reset_pin_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_rr(wr_rr),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .bus_off(bus_off), .bit_strobe(bit_strobe), .rx_bit(rx_bit),
    .rst_mode(rst_mode), .frame_abort(frame_abort), .bus_on(bus_on)
  );

  always @(posedge clk) if (frame_abort) aborts++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic v);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_rr = v;
    @(negedge clk); wr_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic b);
    @(negedge clk); bit_strobe = 1'b1; rx_bit = b;
    @(negedge clk); bit_strobe = 1'b0; rx_bit = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_run(input int n);
    for (int i = 0; i < n; i++) send(1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int a0;
    rst_n = 1'b0; reset_pin_n = 1'b1; wr_en = 1'b0; wr_rr = 1'b0; wr_addr = 2'd0;
    rd_addr = 2'd0; bus_off = 1'b0; bit_strobe = 1'b0; rx_bit = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1: reset state
    chk(rst_mode == 1'b1, "R1 rst_mode", rst_mode, 1);
    chk(bus_on == 1'b0, "R1 bus_on", bus_on, 0);
    chk(rd_data == 8'h01, "R1 read ctrl", rd_data, 1);
    rd_addr = 2'd1; #1;
    chk(rd_data == 8'hFF, "R2 read cmd", rd_data, 255);
    rd_addr = 2'd0;

    // R3: release by write, read reflects it
    wr(2'd0, 1'b0);
    chk(rst_mode == 1'b0, "R3 rst_mode after write 0", rst_mode, 0);
    chk(rd_data == 8'h00, "R3 read ctrl", rd_data, 0);

    // R4: one bus-free interval
    send_run(10);
    chk(bus_on == 1'b0, "R4 10 recessive", bus_on, 0);
    send(1'b1);
    chk(bus_on == 1'b1, "R4 11 recessive", bus_on, 1);

    // R9/R10: request again
    a0 = aborts;
    wr(2'd0, 1'b1);
    chk(rst_mode == 1'b1, "R3 rst_mode after write 1", rst_mode, 1);
    chk(bus_on == 1'b0, "R10 bus_on dropped", bus_on, 0);
    chk(aborts == a0 + 1, "R9 one abort", aborts, a0 + 1);
    wr(2'd0, 1'b1);
    chk(aborts == a0 + 1, "R9 no abort when already set", aborts, a0 + 1);

    // R5: sweep dominant position over the run
    for (int k = 0; k < 11; k++) begin
      wr(2'd0, 1'b0);
      send_run(k);
      send(1'b0);
      send_run(10);
      chk(bus_on == 1'b0, $sformatf("R5 dominant at %0d", k), bus_on, 0);
      send(1'b1);
      chk(bus_on == 1'b1, $sformatf("R5 restart complete %0d", k), bus_on, 1);
      wr(2'd0, 1'b1);
    end

    // R8: re-request during wait clears counts
    wr(2'd0, 1'b0);
    send_run(5);
    wr(2'd0, 1'b1);
    chk(rst_mode == 1'b1, "R8 re-request", rst_mode, 1);
    wr(2'd0, 1'b0);
    send_run(10);
    chk(bus_on == 1'b0, "R8 count cleared", bus_on, 0);
    send(1'b1);
    chk(bus_on == 1'b1, "R8 fresh interval", bus_on, 1);

    // R6: bus-off recovery needs 128 intervals
    a0 = aborts;
    @(negedge clk); bus_off = 1'b1;
    repeat (4) @(negedge clk); bus_off = 1'b0;
    repeat (2) @(negedge clk);
    chk(rst_mode == 1'b1, "R6 bus-off forces request", rst_mode, 1);
    chk(bus_on == 1'b0, "R6 bus_on off", bus_on, 0);
    chk(aborts == a0 + 1, "R9 abort on bus-off", aborts, a0 + 1);
    wr(2'd0, 1'b0);
    send_run(11 * 128 - 1);
    chk(bus_on == 1'b0, "R6 one bit short of 128 intervals", bus_on, 0);
    send(1'b1);
    chk(bus_on == 1'b1, "R6 after 128 intervals", bus_on, 1);

    // R7: pin held low
    @(negedge clk); reset_pin_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(rst_mode == 1'b1, "R7 pin forces request", rst_mode, 1);
    chk(bus_on == 1'b0, "R7 bus_on off", bus_on, 0);
    wr(2'd0, 1'b0);
    chk(rst_mode == 1'b1, "R7 write 0 ignored", rst_mode, 1);
    reset_pin_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(rst_mode == 1'b1, "R7 stays set after pin release", rst_mode, 1);
    wr(2'd0, 1'b0);
    chk(rst_mode == 1'b0, "R7 release by write", rst_mode, 0);
    send_run(10);
    chk(bus_on == 1'b0, "R7 local cause 10 bits", bus_on, 0);
    send(1'b1);
    chk(bus_on == 1'b1, "R7 local cause one interval", bus_on, 1);

    // R2: command address write does not touch the request
    wr(2'd1, 1'b1);
    chk(rst_mode == 1'b0, "R2 cmd write no effect", rst_mode, 0);
    chk(bus_on == 1'b1, "R2 bus_on kept", bus_on, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule